// File: doc/BRIEF.md
# Per-Round Key Derivation and Parity-Matched Response Generator

This block produces the responding side's word in one round of a lightweight challenge–response exchange. Two shared keys are loaded once. After that, every round gets a new round key. The block then returns a tag word whose bitwise-AND parity with that round key equals a target bit. The target bit is the parity of the reader's challenge ANDed with the second key, XORed with a noise bit supplied from outside.

A random word comes in with each round. If its parity against the round key already equals the target, it goes out unchanged. If not, the block flips one bit: the lowest position at which the round key holds a one. No second random word is ever needed.

A mode input picks how the round key is made. The rotate mode evolves the stored keys from round to round. The mix mode computes a one-way value from the first key and the challenge, using fixed half-width logic and a constant. The random source and the noise source are outside this block.

Top module: `rndkey_resp`

## Requirements
- R1: While reset is high, and in the cycle after it, `resp_valid` and `resp_err` are 0 and `resp_word` is all zeros.
- R2: A `load` pulse stores `key_a` as the primary key and `key_b` as the secondary key. In rotate mode (`mode`=0), each round first rotates the primary key left by one position if the secondary key's MSB is 1, and leaves it unchanged if that MSB is 0. The round key is this updated primary key. The secondary key is also rotated left by one, and the new value is kept for the next round.
- R3: The target bit is the XOR over all bits of (challenge AND the secondary key as it stood before that round's update), XORed with `noise`.
- R4: When `resp_err` is 0, the XOR over all bits of (`resp_word` AND the round key) equals the target bit.
- R5: If the parity of the random word against the round key already equals the target, `resp_word` equals the random word.
- R6: Otherwise, `resp_word` is the random word with exactly one bit inverted. That bit is the lowest-indexed position where the round key is 1.
- R7: In mix mode (`mode`=1), let A be the challenge low half, C the challenge high half, B the primary key low half and D the primary key high half. Then F = (B & D) | (~B ^ K) | B, with K = 0x9E3779B7. The round key is {F ^ C, F ^ A}. A mix-mode round leaves both stored keys unchanged.
- R8: If the round key is all zeros, `resp_word` equals the random word and `resp_err` is 1.
- R9: `go` is sampled at a rising edge. `resp_valid` is then 1 for exactly one cycle, after the following rising edge, and 0 in the cycle in between.
- R10: If `go` and `load` are both high in the same cycle, the keys are loaded and no round is run: `resp_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Store key_a and key_b as the round keys' seeds |
| key_a | input | W | Primary shared key |
| key_b | input | W | Secondary shared key |
| mode | input | 1 | 0 = rotate, 1 = mix |
| go | input | 1 | Start one round; this is the key-update pulse |
| challenge | input | W | Reader challenge |
| rnd_word | input | W | Random word for this round |
| noise | input | 1 | Noise bit for this round |
| resp_valid | output | 1 | Response word valid (one-cycle pulse) |
| resp_word | output | W | Tag response word |
| resp_err | output | 1 | Round key was all zeros |

## Verification
Every round's results are due at the same point. The round key and the captured operands are registered at the edge that samples `go`. The word, the error flag and the valid pulse are registered at the next edge. The bench raises `go` at a falling edge and drops it at the next falling edge. It checks that valid is still low at that moment, then reads all three outputs one full cycle later. An independent model tracks both keys across rounds and modes. From that model the bench computes the round key, the target and the expected word, so both the matching and the bit-flip branches are checked against arithmetic rather than against the design.

// File: rtl/rndkey_resp_pkg.sv
package rndkey_resp_pkg;
  typedef enum logic {
    RK_ROTATE = 1'b0,
    RK_MIX    = 1'b1
  } rk_mode_e;

  localparam int unsigned DEF_WIDTH = 64;
endpackage

// File: rtl/rndkey_resp_dot.sv
module rndkey_resp_dot #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] vec_a,
  input  logic [W-1:0] vec_b,
  output logic         par
);
  logic [W-1:0] prod;
  logic [W:0]   acc;

  assign prod   = vec_a & vec_b;
  assign acc[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_fold
    assign acc[i+1] = acc[i] ^ prod[i];
  end

  assign par = acc[W];
endmodule

// File: rtl/rndkey_resp_keygen.sv
module rndkey_resp_keygen
  import rndkey_resp_pkg::*;
#(
  parameter int unsigned     W         = 64,
  parameter int unsigned     HALF      = W / 2,
  parameter logic [HALF-1:0] MIX_CONST = HALF'(32'h9E3779B7)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] key_a,
  input  logic [W-1:0] key_b,
  input  logic         step,
  input  rk_mode_e     mode,
  input  logic [W-1:0] challenge,
  output logic [W-1:0] round_key,
  output logic [W-1:0] sec_key
);
  logic [W-1:0]    pri_q, sec_q;
  logic [W-1:0]    pri_rot, sec_rot;
  logic [HALF-1:0] mb, md, ma, mc, ft;
  logic [W-1:0]    mix_key;

  // rotate path: primary moves by the secondary's MSB, secondary by one
  assign pri_rot = sec_q[W-1] ? {pri_q[W-2:0], pri_q[W-1]} : pri_q;
  assign sec_rot = {sec_q[W-2:0], sec_q[W-1]};

  // one-way mixing path
  assign ma      = challenge[HALF-1:0];
  assign mc      = challenge[W-1:HALF];
  assign mb      = pri_q[HALF-1:0];
  assign md      = pri_q[W-1:HALF];
  assign ft      = (mb & md) | (~mb ^ MIX_CONST) | mb;
  assign mix_key = {ft ^ mc, ft ^ ma};

  always_comb begin
    unique case (mode)
      RK_MIX:    round_key = mix_key;
      default:   round_key = pri_rot;
    endcase
  end

  assign sec_key = sec_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pri_q <= '0;
      sec_q <= '0;
    end else if (load) begin
      pri_q <= key_a;
      sec_q <= key_b;
    end else if (step && mode == RK_ROTATE) begin
      pri_q <= pri_rot;
      sec_q <= sec_rot;
    end
  end
endmodule

// File: rtl/rndkey_resp_fixup.sv
module rndkey_resp_fixup #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] round_key,
  input  logic [W-1:0] rnd_word,
  input  logic         target,
  output logic [W-1:0] word_out,
  output logic         zero_key
);
  logic         cur_par;
  logic [W:0]   seen;
  logic [W-1:0] lowest;

  rndkey_resp_dot #(.W(W)) u_dot (
    .vec_a (rnd_word),
    .vec_b (round_key),
    .par   (cur_par)
  );

  // one-hot of the lowest set bit of the round key
  assign seen[0] = 1'b0;
  for (genvar i = 0; i < W; i++) begin : g_low
    assign lowest[i]  = round_key[i] & ~seen[i];
    assign seen[i+1]  = seen[i] | round_key[i];
  end

  assign zero_key = ~seen[W];

  always_comb begin
    if (zero_key || cur_par == target) word_out = rnd_word;
    else                               word_out = rnd_word ^ lowest;
  end
endmodule

// File: rtl/rndkey_resp.sv
module rndkey_resp
  import rndkey_resp_pkg::*;
#(
  parameter int unsigned     W         = DEF_WIDTH,
  parameter int unsigned     HALF      = W / 2,
  parameter logic [HALF-1:0] MIX_CONST = HALF'(32'h9E3779B7)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] key_a,
  input  logic [W-1:0] key_b,
  input  logic         mode,
  input  logic         go,
  input  logic [W-1:0] challenge,
  input  logic [W-1:0] rnd_word,
  input  logic         noise,
  output logic         resp_valid,
  output logic [W-1:0] resp_word,
  output logic         resp_err
);
  logic         step;
  rk_mode_e     mode_e;
  logic [W-1:0] rk_next, sec_now;

  logic         run_q;
  logic [W-1:0] rk_q, chal_q, tkey_q, rnd_q;
  logic         noise_q;

  logic         tgt_dot, target;
  logic [W-1:0] fixed_word;
  logic         zero_key;

  assign step   = go & ~load;
  assign mode_e = rk_mode_e'(mode);

  rndkey_resp_keygen #(.W(W), .HALF(HALF), .MIX_CONST(MIX_CONST)) u_keygen (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .key_a     (key_a),
    .key_b     (key_b),
    .step      (step),
    .mode      (mode_e),
    .challenge (challenge),
    .round_key (rk_next),
    .sec_key   (sec_now)
  );

  // stage 1: round key and operands
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      rk_q    <= '0;
      chal_q  <= '0;
      tkey_q  <= '0;
      rnd_q   <= '0;
      noise_q <= 1'b0;
    end else begin
      run_q <= step;
      if (step) begin
        rk_q    <= rk_next;
        chal_q  <= challenge;
        tkey_q  <= sec_now;
        rnd_q   <= rnd_word;
        noise_q <= noise;
      end
    end
  end

  rndkey_resp_dot #(.W(W)) u_tgt (
    .vec_a (chal_q),
    .vec_b (tkey_q),
    .par   (tgt_dot)
  );
  assign target = tgt_dot ^ noise_q;

  rndkey_resp_fixup #(.W(W)) u_fix (
    .round_key (rk_q),
    .rnd_word  (rnd_q),
    .target    (target),
    .word_out  (fixed_word),
    .zero_key  (zero_key)
  );

  // stage 2: registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_word  <= '0;
      resp_err   <= 1'b0;
    end else begin
      resp_valid <= run_q;
      if (run_q) begin
        resp_word <= fixed_word;
        resp_err  <= zero_key;
      end else begin
        resp_err  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rndkey_resp_chk.sv
module rndkey_resp_chk #(
  parameter int unsigned W = 64
) (
  input logic         clk,
  input logic         rst,
  input logic         go,
  input logic         load,
  input logic [W-1:0] rnd_word,
  input logic [W-1:0] rk_q,
  input logic [W-1:0] chal_q,
  input logic [W-1:0] tkey_q,
  input logic         noise_q,
  input logic         resp_valid,
  input logic [W-1:0] resp_word,
  input logic         resp_err
);
  // R9
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    (go && !load) |=> (!resp_valid ##1 resp_valid));

  // R10
  go_with_load_chk: assert property (@(posedge clk) disable iff (rst)
    (go && load) |=> ##1 !resp_valid);

  // R4
  parity_chk: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !resp_err) |->
      ((^(resp_word & $past(rk_q))) == ((^($past(chal_q) & $past(tkey_q))) ^ $past(noise_q))));

  // R6
  one_flip_chk: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> ($countones(resp_word ^ $past(rnd_word, 2)) <= 1));

  // R8
  err_word_chk: assert property (@(posedge clk) disable iff (rst)
    resp_err |-> (resp_valid && resp_word == $past(rnd_word, 2)));

  // R1
  err_only_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !resp_valid |-> !resp_err);
endmodule

bind rndkey_resp rndkey_resp_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .go         (go),
  .load       (load),
  .rnd_word   (rnd_word),
  .rk_q       (rk_q),
  .chal_q     (chal_q),
  .tkey_q     (tkey_q),
  .noise_q    (noise_q),
  .resp_valid (resp_valid),
  .resp_word  (resp_word),
  .resp_err   (resp_err)
);

// File: tb/rndkey_resp_test.sv
module rndkey_resp_test;
  localparam int W = 64;
  localparam int H = W / 2;
  localparam logic [H-1:0] KC = 32'h9E3779B7;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         load = 1'b0, mode = 1'b0, go = 1'b0, noise = 1'b0;
  logic [W-1:0] key_a = '0, key_b = '0, challenge = '0, rnd_word = '0;
  logic         resp_valid, resp_err;
  logic [W-1:0] resp_word;

  int errors = 0;
  int checks = 0;
  logic [W-1:0] m_pri, m_sec, seed;
  int flips = 0, keeps = 0;

  always #2 clk = ~clk;

  rndkey_resp uut (
    .clk(clk), .rst(rst), .load(load), .key_a(key_a), .key_b(key_b),
    .mode(mode), .go(go), .challenge(challenge), .rnd_word(rnd_word),
    .noise(noise), .resp_valid(resp_valid), .resp_word(resp_word),
    .resp_err(resp_err)
  );

  function automatic logic [W-1:0] nxt(input logic [W-1:0] s);
    logic [W-1:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 7);
    x = x ^ (x << 17);
    return x;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    load = 1'b1; key_a = a; key_b = b;
    @(negedge clk);
    load = 1'b0;
    m_pri = a; m_sec = b;
  endtask

  task automatic do_round(input logic md, input logic [W-1:0] ch,
                          input logic [W-1:0] rw, input logic nz);
    logic [W-1:0] rk, ex, f2;
    logic [H-1:0] ft;
    logic tgt, ee;
    tgt = (^(ch & m_sec)) ^ nz;   // R3
    if (md) begin                 // R7
      ft = (m_pri[H-1:0] & m_pri[W-1:H]) | (~m_pri[H-1:0] ^ KC) | m_pri[H-1:0];
      rk = {ft ^ ch[W-1:H], ft ^ ch[H-1:0]};
    end else begin                // R2
      if (m_sec[W-1]) m_pri = {m_pri[W-2:0], m_pri[W-1]};
      m_sec = {m_sec[W-2:0], m_sec[W-1]};
      rk = m_pri;
    end
    ee = (rk == '0);
    if (ee || (^(rw & rk)) == tgt) begin
      ex = rw; keeps++;           // R5 / R8
    end else begin
      ex = rw ^ (rk & (~rk + 1'b1)); flips++;  // R6
    end
    @(negedge clk);
    mode = md; challenge = ch; rnd_word = rw; noise = nz; go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    check("R9 valid low mid", W'(resp_valid), W'(0));
    @(negedge clk);
    check("R9 valid high", W'(resp_valid), W'(1));
    check("R5/R6/R7/R2 word", resp_word, ex);
    check("R8 err", W'(resp_err), W'(ee));
    if (!ee) begin
      f2 = resp_word & rk;
      check("R4 parity", W'(^f2), W'(tgt));
    end
    @(negedge clk);
    check("R9 pulse one cycle", W'(resp_valid), W'(0));
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid in reset", W'(resp_valid), W'(0));
    check("R1 word in reset", resp_word, W'(0));
    rst = 1'b0;
    @(negedge clk);
    check("R1 err after reset", W'(resp_err), W'(0));
    check("R1 valid after reset", W'(resp_valid), W'(0));

    // rotate mode with MSB patterns
    do_load(64'h0000_0000_0000_0001, 64'h8000_0000_0000_0000);
    for (int i = 0; i < 4; i++)
      do_round(1'b0, 64'hFFFF_0000_FFFF_0000, 64'h0, 1'b1);

    // all-zero round key
    do_load('0, 64'hA5A5_A5A5_A5A5_A5A5);
    do_round(1'b0, 64'h1234_5678_9ABC_DEF0, 64'hDEAD_BEEF_0BAD_F00D, 1'b0);
    do_round(1'b0, 64'h0, 64'h0000_0000_0000_00FF, 1'b1);

    // R10: go together with load
    @(negedge clk);
    load = 1'b1; go = 1'b1; key_a = 64'h0F0F_0F0F_0F0F_0F0F; key_b = 64'h1;
    @(negedge clk);
    load = 1'b0; go = 1'b0;
    m_pri = 64'h0F0F_0F0F_0F0F_0F0F; m_sec = 64'h1;
    check("R10 no valid a", W'(resp_valid), W'(0));
    @(negedge clk);
    check("R10 no valid b", W'(resp_valid), W'(0));
    do_round(1'b0, 64'h3, 64'h5, 1'b0);

    // sweep of mixed modes and random operands
    seed = 64'h0123_4567_89AB_CDEF;
    for (int r = 0; r < 300; r++) begin
      logic [W-1:0] c, w;
      if (r % 50 == 0) begin
        seed = nxt(seed); c = seed;
        seed = nxt(seed);
        do_load(c, seed);
      end
      seed = nxt(seed); c = seed;
      seed = nxt(seed); w = seed;
      do_round(seed[5] ^ seed[11], c, w, seed[40]);
    end

    check("R6 flip branch seen", W'(flips > 0), W'(1));
    check("R5 keep branch seen", W'(keeps > 0), W'(1));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule